// File: doc/BRIEF.md
# Three-Stage Add-Multiply-Add Pipeline

This block is a streaming arithmetic unit. It evaluates f = A + ((B + C) * D) on four signed operands. It accepts a new operand set on every clock and returns one result per clock once it is full.

The expression is split at fixed points into three register-bounded stages, so no combinational path contains more than one arithmetic operator:

1. The first stage registers the sum of B and C.
2. The second stage multiplies that registered sum by D.
3. The third stage adds A.

Operands that are needed later are carried through matching delay registers, so every result stays paired with the inputs it came from. A valid flag travels in step with the data. All intermediate values are kept at full precision, so the result never overflows.

A producer asserts `in_valid` together with an operand set. Exactly three cycles later the consumer sees `out_valid` together with the result. There is no stall or backpressure path: the stream moves forward on every clock.

Top module: `amad_pipe`

## Requirements
- R1: When `out_valid` is high, `f_out` equals A + ((B + C) * D) computed exactly from one operand set presented with `in_valid` high. This holds for every input, including the most positive and most negative signed values of each operand width.
- R2: The first stage registers B + C at width max(B_W, C_W) + 1, with both operands sign-extended.
- R3: The second stage registers the product of the registered sum and a copy of D that has been delayed by one register. The product width is the sum width plus D_W.
- R4: The third stage registers the product plus a copy of A that has been delayed by two registers. The result width is max(A_W, product width) + 1.
- R5: An operand set presented in the cycle before clock edge k appears on the outputs just after edge k+2. That is three cycles after it is presented, counting the cycle in which it is presented.
- R6: Back-to-back operand sets, one per cycle, each produce their own result in consecutive cycles.
- R7: `out_valid` is high in a cycle exactly when `in_valid` was high three cycles earlier. Every gap in `in_valid` reappears as a gap of the same length in `out_valid`.
- R8: A synchronous active-high `rst` clears every valid stage. `out_valid` is low after any clock edge at which `rst` is high. No operand set that was in flight at reset is ever reported.
- R9: Operand values presented while `in_valid` is low have no effect on any result that is reported with `out_valid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set on the inputs is valid this cycle |
| a_in | input | A_W | Signed operand A |
| b_in | input | B_W | Signed operand B |
| c_in | input | C_W | Signed operand C |
| d_in | input | D_W | Signed operand D |
| out_valid | output | 1 | `f_out` holds a valid result |
| f_out | output | max(A_W, max(B_W,C_W)+1+D_W)+1 | Signed result |

## Verification
The bench builds the block with unequal operand widths: A_W=10, B_W=8, C_W=6, D_W=7. This makes the sum width follow the wider of B and C, and makes the final adder extend A from 10 bits up to a 17-bit result. With these narrow widths, corner values such as B = C = minimum and D = minimum can be reached on purpose, and they drive the product and the result to the edges of their ranges. Random streams, streams with valid gaps, and a reset in the middle of a stream are each compared against a queued behavioural model on every cycle.

// File: rtl/amad_pkg.sv
package amad_pkg;

    function automatic int wmax(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    function automatic int sum_w(input int bw, input int cw);
        return wmax(bw, cw) + 1;
    endfunction

    function automatic int prod_w(input int bw, input int cw, input int dw);
        return sum_w(bw, cw) + dw;
    endfunction

    function automatic int res_w(input int aw, input int bw, input int cw, input int dw);
        return wmax(aw, prod_w(bw, cw, dw)) + 1;
    endfunction

endpackage

// File: rtl/amad_dly.sv
module amad_dly #(
    parameter int W = 8,
    parameter int N = 1
) (
    input  logic                clk,
    input  logic signed [W-1:0] d_i,
    output logic signed [W-1:0] d_o
);
    logic signed [W-1:0] tap [N+1];

    assign tap[0] = d_i;

    for (genvar g = 0; g < N; g++) begin : g_tap
        always_ff @(posedge clk) begin
            tap[g+1] <= tap[g];
        end
    end

    assign d_o = tap[N];
endmodule

// File: rtl/amad_vpipe.sv
module amad_vpipe #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         v_i,
    output logic [N-1:0] v_o
);
    for (genvar g = 0; g < N; g++) begin : g_vs
        always_ff @(posedge clk) begin
            if (rst) begin
                v_o[g] <= 1'b0;
            end else begin
                if (g == 0) v_o[g] <= v_i;
                else        v_o[g] <= v_o[(g == 0) ? 0 : g-1];
            end
        end
    end
endmodule

// File: rtl/amad_sum.sv
module amad_sum #(
    parameter int BW = 8,
    parameter int CW = 8,
    parameter int SW = 9
) (
    input  logic                 clk,
    input  logic signed [BW-1:0] b_i,
    input  logic signed [CW-1:0] c_i,
    output logic signed [SW-1:0] s_o
);
    logic signed [SW-1:0] b_x, c_x;

    assign b_x = SW'(b_i);
    assign c_x = SW'(c_i);

    always_ff @(posedge clk) begin
        s_o <= b_x + c_x;
    end
endmodule

// File: rtl/amad_mul.sv
module amad_mul #(
    parameter int SW = 9,
    parameter int DW = 8,
    parameter int PW = 17
) (
    input  logic                 clk,
    input  logic signed [SW-1:0] s_i,
    input  logic signed [DW-1:0] d_i,
    output logic signed [PW-1:0] p_o
);
    logic signed [PW-1:0] s_x, d_x, prod;

    assign s_x  = PW'(s_i);
    assign d_x  = PW'(d_i);
    assign prod = s_x * d_x;

    always_ff @(posedge clk) begin
        p_o <= prod;
    end
endmodule

// File: rtl/amad_fin.sv
module amad_fin #(
    parameter int AW = 8,
    parameter int PW = 17,
    parameter int RW = 18
) (
    input  logic                 clk,
    input  logic signed [AW-1:0] a_i,
    input  logic signed [PW-1:0] p_i,
    output logic signed [RW-1:0] f_o
);
    logic signed [RW-1:0] a_x, p_x;

    assign a_x = RW'(a_i);
    assign p_x = RW'(p_i);

    always_ff @(posedge clk) begin
        f_o <= a_x + p_x;
    end
endmodule

// File: rtl/amad_pipe.sv
module amad_pipe #(
    parameter int A_W = 16,
    parameter int B_W = 16,
    parameter int C_W = 16,
    parameter int D_W = 16,
    localparam int SW = amad_pkg::sum_w(B_W, C_W),
    localparam int PW = amad_pkg::prod_w(B_W, C_W, D_W),
    localparam int RW = amad_pkg::res_w(A_W, B_W, C_W, D_W)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic signed [A_W-1:0] a_in,
    input  logic signed [B_W-1:0] b_in,
    input  logic signed [C_W-1:0] c_in,
    input  logic signed [D_W-1:0] d_in,
    output logic                  out_valid,
    output logic signed [RW-1:0]  f_out
);
    localparam int NSTG = 3;

    logic [NSTG-1:0]       vq;
    logic signed [SW-1:0]  s_q;
    logic signed [D_W-1:0] d_q;
    logic signed [A_W-1:0] a_q;
    logic signed [PW-1:0]  p_q;

    amad_vpipe #(.N(NSTG)) u_vp (
        .clk(clk), .rst(rst), .v_i(in_valid), .v_o(vq)
    );

    amad_dly #(.W(D_W), .N(1)) u_dd (
        .clk(clk), .d_i(d_in), .d_o(d_q)
    );

    amad_dly #(.W(A_W), .N(2)) u_ad (
        .clk(clk), .d_i(a_in), .d_o(a_q)
    );

    amad_sum #(.BW(B_W), .CW(C_W), .SW(SW)) u_s1 (
        .clk(clk), .b_i(b_in), .c_i(c_in), .s_o(s_q)
    );

    amad_mul #(.SW(SW), .DW(D_W), .PW(PW)) u_s2 (
        .clk(clk), .s_i(s_q), .d_i(d_q), .p_o(p_q)
    );

    amad_fin #(.AW(A_W), .PW(PW), .RW(RW)) u_s3 (
        .clk(clk), .a_i(a_q), .p_i(p_q), .f_o(f_out)
    );

    assign out_valid = vq[NSTG-1];
endmodule

// File: rtl/amad_chk.sv
module amad_chk #(
    parameter int A_W = 16,
    parameter int B_W = 16,
    parameter int C_W = 16,
    parameter int D_W = 16,
    parameter int SW  = 17,
    parameter int PW  = 33,
    parameter int RW  = 34
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic signed [A_W-1:0] a_in,
    input logic signed [B_W-1:0] b_in,
    input logic signed [C_W-1:0] c_in,
    input logic signed [D_W-1:0] d_in,
    input logic [2:0]            vq,
    input logic signed [SW-1:0]  s_q,
    input logic signed [D_W-1:0] d_q,
    input logic signed [A_W-1:0] a_q,
    input logic signed [PW-1:0]  p_q,
    input logic                  out_valid,
    input logic signed [RW-1:0]  f_out
);
    logic [1:0] run_n;

    always_ff @(posedge clk) begin
        if (rst)              run_n <= 2'd0;
        else if (run_n != 2'd3) run_n <= run_n + 2'd1;
    end

    // R8: reset clears the output valid
    a_r8_reset_clears: assert property (@(posedge clk) rst |=> !out_valid);

    // R7 and R5: valid leaves three cycles after it enters
    a_r7_valid_delay: assert property (@(posedge clk) disable iff (rst)
        (run_n == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R2: the first stage holds the extended sum
    a_r2_sum_stage: assert property (@(posedge clk) disable iff (rst)
        vq[0] |-> (s_q == SW'($past(b_in)) + SW'($past(c_in))));

    // R3: the second stage multiplies the sum by the delayed D
    a_r3_prod_stage: assert property (@(posedge clk) disable iff (rst)
        vq[1] |-> (p_q == PW'($past(s_q)) * PW'($past(d_q))));

    // R4: the third stage adds the twice-delayed A
    a_r4_final_stage: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (f_out == RW'($past(a_q)) + RW'($past(p_q))));

    // R1: end-to-end value against operands three cycles back
    a_r1_end_to_end: assert property (@(posedge clk) disable iff (rst)
        (out_valid && run_n == 2'd3) |->
        (f_out == RW'($past(a_in, 3)) +
                  (RW'($past(b_in, 3)) + RW'($past(c_in, 3))) * RW'($past(d_in, 3))));
endmodule

bind amad_pipe amad_chk #(
    .A_W(A_W), .B_W(B_W), .C_W(C_W), .D_W(D_W), .SW(SW), .PW(PW), .RW(RW)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in),
    .vq(vq), .s_q(s_q), .d_q(d_q), .a_q(a_q), .p_q(p_q),
    .out_valid(out_valid), .f_out(f_out)
);

// File: tb/tb_amad_pipe.sv
module tb_amad_pipe;
    localparam int AW = 10;
    localparam int BW = 8;
    localparam int CW = 6;
    localparam int DW = 7;
    localparam int RW = amad_pkg::res_w(AW, BW, CW, DW);

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 in_valid;
    logic signed [AW-1:0] a_in;
    logic signed [BW-1:0] b_in;
    logic signed [CW-1:0] c_in;
    logic signed [DW-1:0] d_in;
    logic                 out_valid;
    logic signed [RW-1:0] f_out;

    typedef struct {
        bit     v;
        longint f;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    amad_pipe #(.A_W(AW), .B_W(BW), .C_W(CW), .D_W(DW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in),
        .out_valid(out_valid), .f_out(f_out)
    );

    task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit rv, input bit v,
                        input logic signed [AW-1:0] a, input logic signed [BW-1:0] b,
                        input logic signed [CW-1:0] c, input logic signed [DW-1:0] d);
        exp_t e;
        @(negedge clk);
        rst = rv; in_valid = v; a_in = a; b_in = b; c_in = c; d_in = d;
        @(posedge clk);
        #1;
        if (rv) begin
            chk("R8 out_valid in reset", out_valid == 1'b0, longint'(out_valid), 0);
            q.delete();
            e.v = 1'b0; e.f = 0;
            q.push_back(e);
            q.push_back(e);
        end else begin
            e.v = v;
            e.f = longint'(a) + (longint'(b) + longint'(c)) * longint'(d);
            q.push_back(e);
            e = q.pop_front();
            chk({tag, " R7 valid"}, out_valid == e.v, longint'(out_valid), longint'(e.v));
            if (e.v)
                chk({tag, " R1 value"}, longint'(f_out) == e.f, longint'(f_out), e.f);
        end
    endtask

    task automatic rnd(input string tag, input bit v);
        step(tag, 1'b0, v, AW'($urandom), BW'($urandom), CW'($urandom), DW'($urandom));
    endtask

    localparam logic signed [AW-1:0] AMX = {1'b0, {(AW-1){1'b1}}};
    localparam logic signed [AW-1:0] AMN = {1'b1, {(AW-1){1'b0}}};
    localparam logic signed [BW-1:0] BMX = {1'b0, {(BW-1){1'b1}}};
    localparam logic signed [BW-1:0] BMN = {1'b1, {(BW-1){1'b0}}};
    localparam logic signed [CW-1:0] CMX = {1'b0, {(CW-1){1'b1}}};
    localparam logic signed [CW-1:0] CMN = {1'b1, {(CW-1){1'b0}}};
    localparam logic signed [DW-1:0] DMX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] DMN = {1'b1, {(DW-1){1'b0}}};

    initial begin
        rst = 1'b1; in_valid = 1'b0; a_in = '0; b_in = '0; c_in = '0; d_in = '0;
        // R8: reset state, with in_valid high during reset
        for (int i = 0; i < 3; i++) step("R8", 1'b1, 1'b1, AMX, BMX, CMX, DMX);
        // R5: first result only after the pipe fills
        step("R5", 1'b0, 1'b1, 10'sd5, 8'sd3, 6'sd4, 7'sd2);
        step("R5", 1'b0, 1'b0, '0, '0, '0, '0);
        step("R5", 1'b0, 1'b0, '0, '0, '0, '0);
        step("R5", 1'b0, 1'b0, '0, '0, '0, '0);
        // R1: extreme operand values, back to back (R6)
        step("R1 min", 1'b0, 1'b1, AMN, BMN, CMN, DMN);
        step("R1 max", 1'b0, 1'b1, AMX, BMX, CMX, DMX);
        step("R1 mix", 1'b0, 1'b1, AMX, BMN, CMN, DMN);
        step("R1 mix", 1'b0, 1'b1, AMN, BMX, CMX, DMN);
        step("R1 mix", 1'b0, 1'b1, AMN, BMN, CMN, DMX);
        step("R1 zero", 1'b0, 1'b1, '0, BMX, CMN, '0);
        // R6: back-to-back random stream
        for (int i = 0; i < 400; i++) rnd("R6", 1'b1);
        // R7 and R9: random gaps, garbage operands while in_valid is low
        for (int i = 0; i < 400; i++) rnd("R9", ($urandom % 3) != 0);
        // R7: isolated single-cycle gaps and pulses
        for (int i = 0; i < 20; i++) rnd("R7", i[0]);
        // R8: reset in the middle of a full stream
        for (int i = 0; i < 3; i++) rnd("R8", 1'b1);
        step("R8", 1'b1, 1'b1, AMX, BMX, CMX, DMX);
        for (int i = 0; i < 4; i++) rnd("R8", 1'b0);
        for (int i = 0; i < 50; i++) rnd("R6", 1'b1);
        for (int i = 0; i < 3; i++) rnd("R7", 1'b0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule